// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the serial slave front end of a 128K x 8 byte-addressed memory. It watches the SPI pins (SCK, chip select, serial in, HOLD) from inside a faster system clock domain. Each pin passes through a two-flop synchronizer, and edges are found by comparing the synchronized level with its previous value. SCK high and low phases must each last at least four system clocks.

A transaction opens when chip select falls. It carries exactly one command, given by an 8-bit opcode sent MSB first. For memory access the opcode is followed by three address bytes and then any number of data bytes. Data in is sampled on SCK rising edges. Read data leaves MSB first and changes after SCK falling edges. The engine drives a simple synchronous memory port and keeps write strobes gated by a permission input from an external protection unit. It emits single-cycle strobes toward a protection unit (write-enable set/clear, status write) and a power-mode unit (sleep/wake). Which SPI clock idle level is in use needs no setting: every action is tied to a rising or falling edge, and the first edge after chip select falls in mode 3 (a falling one) lands in the command phase, where falling edges do nothing.

Top module: `spi_mem_engine`

## Requirements
- R1: After reset, so_en, mem_we, sr_we, wel_set, wel_clr, sleep_req and wake_req are all low.
- R2: Opcode 8'h06 pulses wel_set, 8'h04 pulses wel_clr, 8'hB9 pulses sleep_req and 8'hAB pulses wake_req. Each pulse lasts one clock and is raised once the eighth opcode bit has been received.
- R3: Opcode 8'h05 shifts out the sr_rdata byte MSB first. Opcode 8'h01 pulses sr_we once, with sr_wdata equal to the byte that follows.
- R4: Opcode 8'h02 followed by a 24-bit address (MSB first) writes each fully received data byte to consecutive addresses, with one mem_we pulse per byte.
- R5: Opcode 8'h03 followed by a 24-bit address returns bytes from consecutive addresses, MSB first, with no gap between bytes, for as long as SCK keeps running.
- R6: Reads and writes behave the same whether SCK idles low (mode 0) or high (mode 3) when chip select falls.
- R7: Only address bits 16:0 are used. After address 17'h1FFFF the next byte goes to address 0.
- R8: A data byte cut short by chip select rising is not written.
- R9: When wr_ok is low for the current address, that byte is dropped, and the next byte still goes to the following address.
- R10: An opcode other than the eight listed, and every byte after a complete 06/04/B9/AB opcode, causes no strobe, no write and no SO drive until chip select rises.
- R11: While hold_n is low, so_en is low and SCK edges are ignored. When hold_n rises again, the transfer resumes at the bit where it stopped.
- R12: so_en is high only during the data phase of opcodes 8'h03 and 8'h05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (asynchronous) |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI serial data in |
| hold_n | input | 1 | Suspend request, active low |
| so_data | output | 1 | Serial data out value |
| so_en | output | 1 | Serial out drive enable (low = high impedance) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_addr |
| wr_ok | input | 1 | Protection permits a write to mem_addr |
| sr_rdata | input | 8 | Status byte to return |
| sr_wdata | output | 8 | Status byte received |
| sr_we | output | 1 | Status write strobe |
| wel_set | output | 1 | Write-enable set strobe |
| wel_clr | output | 1 | Write-enable clear strobe |
| sleep_req | output | 1 | Sleep request strobe |
| wake_req | output | 1 | Wake request strobe |

## Verification
A wrong bit or byte count shows at the ports within one byte time. The opcode is decoded wrongly, the address lands on the wrong byte, or SO comes out shifted against the master's sampling point. Any of these makes the read-back data or the strobe counts differ on the first transfer that uses it. A bad address counter or prefetch only becomes visible at a byte boundary, so every stream test crosses several boundaries and the address wrap. A stuck hold or select state shows as so_en staying wrong during the next read, or as an extra or missing mem_we pulse.

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          hold_n,
  output logic          so_data,
  output logic          so_en,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  input  logic [7:0]    mem_rdata,
  input  logic          wr_ok,
  input  logic [7:0]    sr_rdata,
  output logic [7:0]    sr_wdata,
  output logic          sr_we,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          sleep_req,
  output logic          wake_req
);
  localparam logic [AW-1:0] ONE = 1;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_RD, S_WR, S_SRR, S_SRW, S_SKIP} st_t;

  st_t           st;
  logic [2:0]    sck_p, cs_p;
  logic [1:0]    si_p, hold_p;
  logic          sel, is_rd, odrv, wpend, f1, f2;
  logic [2:0]    bcnt, ocnt;
  logic [1:0]    acnt;
  logic [6:0]    shreg;
  logic [7:0]    oshift, obuf, wbyte;
  logic [AW-1:0] addr;

  wire go        = hold_p[1];
  wire sck_rise  = go & sel & sck_p[1] & ~sck_p[2];
  wire sck_fall  = go & sel & ~sck_p[1] & sck_p[2];
  wire cs_fall   = go & ~cs_p[1] & cs_p[2];
  wire cs_rise   = go & cs_p[1] & ~cs_p[2];
  wire [7:0] byte_in = {shreg, si_p[1]};
  wire byte_done = sck_rise & (bcnt == 3'd7);
  wire out_phase = (st == S_RD) | (st == S_SRR);

  assign so_data   = oshift[7];
  assign so_en     = sel & odrv & go;
  assign mem_addr  = addr;
  assign mem_wdata = wbyte;
  assign mem_we    = wpend & wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      si_p   <= '0;
      hold_p <= '1;
    end else begin
      sck_p  <= {sck_p[1:0], sck};
      cs_p   <= {cs_p[1:0], cs_n};
      si_p   <= {si_p[0], si};
      hold_p <= {hold_p[0], hold_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SKIP; sel <= 1'b0; is_rd <= 1'b0; odrv <= 1'b0;
      wpend <= 1'b0; f1 <= 1'b0; f2 <= 1'b0;
      bcnt <= '0; ocnt <= '0; acnt <= '0; shreg <= '0;
      oshift <= '0; obuf <= '0; wbyte <= '0; addr <= '0; sr_wdata <= '0;
      sr_we <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
      sleep_req <= 1'b0; wake_req <= 1'b0;
    end else begin
      sr_we <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
      sleep_req <= 1'b0; wake_req <= 1'b0;
      f1 <= 1'b0;
      f2 <= f1;
      if (f2) obuf <= mem_rdata;
      if (wpend) begin
        addr  <= addr + ONE;
        wpend <= 1'b0;
      end
      if (cs_fall) begin
        sel <= 1'b1; st <= S_CMD; bcnt <= '0; acnt <= '0; ocnt <= '0; odrv <= 1'b0;
      end else if (cs_rise) begin
        sel <= 1'b0; odrv <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg <= byte_in[6:0];
          bcnt  <= bcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            S_CMD: begin
              st <= S_SKIP;
              case (byte_in)
                8'h06: wel_set   <= 1'b1;
                8'h04: wel_clr   <= 1'b1;
                8'hB9: sleep_req <= 1'b1;
                8'hAB: wake_req  <= 1'b1;
                8'h05: st <= S_SRR;
                8'h01: st <= S_SRW;
                8'h03: begin st <= S_ADDR; is_rd <= 1'b1; end
                8'h02: begin st <= S_ADDR; is_rd <= 1'b0; end
                default: ;
              endcase
            end
            S_ADDR: begin
              addr <= {addr[AW-9:0], byte_in};
              acnt <= acnt + 2'd1;
              if (acnt == 2'd2) begin
                st <= is_rd ? S_RD : S_WR;
                f1 <= is_rd;
              end
            end
            S_WR: begin
              wbyte <= byte_in;
              wpend <= 1'b1;
            end
            S_SRW: begin
              sr_wdata <= byte_in;
              sr_we    <= 1'b1;
              st       <= S_SKIP;
            end
            default: ;
          endcase
        end
        if (sck_fall && out_phase) begin
          odrv <= 1'b1;
          ocnt <= ocnt + 3'd1;
          if (ocnt == 3'd0) begin
            oshift <= (st == S_RD) ? obuf : sr_rdata;
            if (st == S_RD) begin
              addr <= addr + ONE;
              f1   <= 1'b1;
            end
          end else begin
            oshift <= {oshift[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_n,
  input logic          so_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          sr_we,
  input logic          wel_set,
  input logic          wel_clr,
  input logic          sleep_req,
  input logic          wake_req
);
  localparam logic [AW-1:0] ONE = 1;

  wire any_cmd = wel_set | wel_clr | sleep_req | wake_req;

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set, wel_clr, sleep_req, wake_req, sr_we, mem_we}));

  p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |=> !any_cmd);

  p_sr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> !sr_we);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == $past(mem_addr) + ONE));

  p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!hold_n, 2) && $past(!hold_n)) |-> !so_en);
endmodule

bind spi_mem_engine spi_mem_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .so_en(so_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .sr_we(sr_we), .wel_set(wel_set), .wel_clr(wel_clr),
  .sleep_req(sleep_req), .wake_req(wake_req)
);

// File: tb/spi_mem_engine_tb.sv
module spi_mem_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam logic [7:0] SR_VAL = 8'hA6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so_data, so_en, mem_we, sr_we, wel_set, wel_clr, sleep_req, wake_req;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata, sr_wdata;
  logic [7:0] rdata_q = 8'h00;
  logic blk = 1'b0;
  logic wr_ok;

  int checks = 0, errors = 0;
  int n_wset = 0, n_wclr = 0, n_slp = 0, n_wak = 0, n_srwe = 0, n_we = 0;
  logic [7:0] last_srw = 8'h00;
  logic en_seen;
  logic m3 = 1'b0;
  logic [7:0] rb [0:7];
  logic [7:0] wbuf [0:7];
  logic [7:0] mem [int];
  logic [7:0] emem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wr_ok = !(blk && mem_addr == 17'h1F000);

  spi_mem_engine #(.AW(17)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so_data(so_data), .so_en(so_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(rdata_q), .wr_ok(wr_ok), .sr_rdata(SR_VAL),
    .sr_wdata(sr_wdata), .sr_we(sr_we), .wel_set(wel_set), .wel_clr(wel_clr),
    .sleep_req(sleep_req), .wake_req(wake_req)
  );

  function automatic logic [7:0] pat(input int a);
    logic [16:0] v;
    v = a[16:0];
    return v[7:0] ^ v[15:8] ^ {7'b0, v[16]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mem_get(input int a);
    if (mem.exists(a)) return mem[a];
    return pat(a);
  endfunction

  function automatic logic [7:0] exp_get(input int a);
    if (emem.exists(a)) return emem[a];
    return pat(a);
  endfunction

  always @(posedge clk) begin
    rdata_q <= mem_get(int'(mem_addr));
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (wel_set) n_wset++;
    if (wel_clr) n_wclr++;
    if (sleep_req) n_slp++;
    if (wake_req) n_wak++;
    if (mem_we) n_we++;
    if (sr_we) begin n_srwe++; last_srw = sr_wdata; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_tx(input logic mode3);
    m3 = mode3;
    sck = mode3;
    wclk(HALF);
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic end_tx;
    if (!m3) begin sck = 1'b0; wclk(HALF); end
    cs_n = 1'b1;
    wclk(2*HALF + 4);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, input int hold_bit, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0; si = tx[i];
      wclk(HALF);
      if (i == hold_bit) begin
        hold_n = 1'b0;
        wclk(4);
        chk("R11 so_en during hold", {31'b0, so_en}, 0);
        for (int k = 0; k < 2; k++) begin
          sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
        end
        chk("R11 so_en after ignored edges", {31'b0, so_en}, 0);
        hold_n = 1'b1;
        wclk(4);
      end
      rx[i] = so_data;
      en_seen = en_seen | so_en;
      sck = 1'b1;
      wclk(HALF);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, -1, rx);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
  endtask

  task automatic do_cmd(input logic [7:0] op);
    logic [7:0] d;
    begin_tx(1'b0); xbyte(op, d); end_tx;
  endtask

  task automatic do_write(input logic mode3, input logic [23:0] a, input int n);
    logic [7:0] d;
    int ea;
    begin_tx(mode3);
    xbyte(8'h02, d); send_addr(a);
    ea = int'(a[16:0]);
    for (int i = 0; i < n; i++) begin
      xbyte(wbuf[i], d);
      if (!(blk && ea == 17'h1F000)) emem[ea] = wbuf[i];
      ea = (ea + 1) & 17'h1FFFF;
    end
    end_tx;
  endtask

  task automatic do_read(input logic mode3, input logic [23:0] a, input int n, input int hold_bit);
    logic [7:0] d;
    begin_tx(mode3);
    xbyte(8'h03, d); send_addr(a);
    en_seen = 1'b0;
    for (int i = 0; i < n; i++) xbits(8'h00, 8, (i == 0) ? hold_bit : -1, rb[i]);
    end_tx;
  endtask

  task automatic chk_read(input string tag, input logic [16:0] a, input int n);
    for (int i = 0; i < n; i++)
      chk(tag, {24'b0, rb[i]}, {24'b0, exp_get(int'((a + 17'(i)) & 17'h1FFFF))});
  endtask

  task automatic t_reset;
    chk("R1 so_en", {31'b0, so_en}, 0);
    chk("R1 mem_we", {31'b0, mem_we}, 0);
    chk("R1 strobes", {27'b0, sr_we, wel_set, wel_clr, sleep_req, wake_req}, 0);
  endtask

  task automatic t_cmds;
    en_seen = 1'b0;
    do_cmd(8'h06); chk("R2 wel_set count", n_wset, 1);
    do_cmd(8'h04); chk("R2 wel_clr count", n_wclr, 1);
    do_cmd(8'hB9); chk("R2 sleep count", n_slp, 1);
    do_cmd(8'hAB); chk("R2 wake count", n_wak, 1);
    chk("R12 no drive in commands", {31'b0, en_seen}, 0);
  endtask

  task automatic t_status;
    logic [7:0] d;
    begin_tx(1'b0); xbyte(8'h05, d);
    en_seen = 1'b0;
    xbyte(8'h00, d); end_tx;
    chk("R3 status read", {24'b0, d}, {24'b0, SR_VAL});
    chk("R12 drive in status read", {31'b0, en_seen}, 1);
    begin_tx(1'b1); xbyte(8'h01, d); xbyte(8'h3C, d); end_tx;
    chk("R3 sr_we count", n_srwe, 1);
    chk("R3 sr_wdata", {24'b0, last_srw}, 32'h3C);
  endtask

  task automatic t_wr_rd;
    int w0;
    w0 = n_we;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    en_seen = 1'b0;
    do_write(1'b0, 24'h001234, 3);
    chk("R4 one strobe per byte", n_we - w0, 3);
    chk("R12 no drive in write", {31'b0, en_seen}, 0);
    do_read(1'b1, 24'h001234, 4, -1);
    chk_read("R5 R6 mode3 read stream", 17'h01234, 4);
    do_read(1'b0, 24'h001233, 3, -1);
    chk_read("R5 mode0 read stream", 17'h01233, 3);
    wbuf[0] = 8'h9E; wbuf[1] = 8'h4D;
    do_write(1'b1, 24'h000400, 2);
    do_read(1'b0, 24'h000400, 2, -1);
    chk_read("R6 mode3 write", 17'h00400, 2);
  endtask

  task automatic t_wrap;
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    do_write(1'b0, 24'hFFFFFF, 2);
    do_read(1'b0, 24'h01FFFF, 3, -1);
    chk_read("R7 wrap read", 17'h1FFFF, 3);
    chk("R7 wrap landed at 0", {24'b0, rb[1]}, 32'hBB);
  endtask

  task automatic t_partial;
    logic [7:0] d;
    int w0;
    w0 = n_we;
    begin_tx(1'b0);
    xbyte(8'h02, d); send_addr(24'h000100);
    xbyte(8'hC3, d); emem[17'h100] = 8'hC3;
    xbits(8'hE7, 5, -1, d);
    end_tx;
    chk("R8 only whole bytes", n_we - w0, 1);
    do_read(1'b0, 24'h000100, 2, -1);
    chk_read("R8 partial not written", 17'h00100, 2);
  endtask

  task automatic t_protect;
    int w0;
    w0 = n_we;
    blk = 1'b1;
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    do_write(1'b0, 24'h01EFFF, 3);
    blk = 1'b0;
    chk("R9 dropped strobe", n_we - w0, 2);
    do_read(1'b0, 24'h01EFFF, 3, -1);
    chk_read("R9 blocked byte kept, next advanced", 17'h1EFFF, 3);
  endtask

  task automatic t_ignore;
    logic [7:0] d;
    int w0, s0;
    w0 = n_we; s0 = n_wset;
    en_seen = 1'b0;
    begin_tx(1'b0);
    xbyte(8'h5A, d); xbyte(8'h02, d); send_addr(24'h000200); xbyte(8'h77, d);
    end_tx;
    chk("R10 unknown opcode no write", n_we - w0, 0);
    chk("R10 unknown opcode no strobe", n_wset + n_wclr + n_slp + n_wak + n_srwe, 5);
    chk("R10 unknown opcode no drive", {31'b0, en_seen}, 0);
    begin_tx(1'b0);
    xbyte(8'h06, d); xbyte(8'h02, d); send_addr(24'h000300); xbyte(8'h88, d);
    end_tx;
    chk("R10 one command per select", n_wset - s0, 1);
    chk("R10 trailing write ignored", n_we - w0, 0);
    do_read(1'b0, 24'h000300, 1, -1);
    chk_read("R10 memory untouched", 17'h00300, 1);
  endtask

  task automatic t_hold;
    do_read(1'b0, 24'h001234, 2, 4);
    chk_read("R11 read resumes after hold", 17'h01234, 2);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset;
    t_cmds;
    t_status;
    t_wr_rd;
    t_wrap;
    t_partial;
    t_protect;
    t_ignore;
    t_hold;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule